// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous request port and an external 8192 x 8 asynchronous static RAM. The RAM has two chip enables of opposite polarity, an active-low write strobe, an active-low output enable and one shared byte-wide data bus. The block turns each accepted request into a timed strobe sequence. Every phase lasts a whole number of clock cycles, derived from the nanosecond limits and the clock period by rounding up.

A user raises `reqValid` with an address, a write flag and, for writes, a data byte. The request is taken only while the sequencer is idle. Completion is signalled by a single-cycle `reqAck`; for reads, `rspRdata` holds the captured byte in that cycle.

The pad-level tri-state buffer lives outside the block. The block drives `memDataOut` and enables the buffer with `memDataOe`. It observes the bus through `memDataIn`. Between accesses the RAM is left deselected.

With default parameters (10 ns clock) the phase lengths are as follows:
- Write: 1 select-setup cycle, 2 write-strobe cycles, 1 hold cycle.
- Read: 3 access cycles followed by 1 release cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `memCe1N`=1, `memCe2`=0, `memWeN`=1, `memOeN`=1, `memDataOe`=0 and `reqAck`=0.
- R2: Whenever the sequencer is not in an access, both chip enables are inactive (`memCe1N`=1, `memCe2`=0) and `memWeN`=1, `memOeN`=1.
- R3: `memWeN` goes low only while the chip is selected and `memOeN` is high. It stays low for exactly the write-strobe cycle count (2 by default). `memAddr` stays unchanged for as long as the chip is selected.
- R4: During a write, `memDataOe` is high and `memDataOut` carries the write byte for the whole strobe. Both persist for at least one cycle after `memWeN` rises. The RAM then holds that byte at that address.
- R5: A read selects the chip with `memOeN`=0 and `memWeN`=1 for the access cycle count (3 by default). The byte on `memDataIn` at the end of the last access cycle is returned on `rspRdata`.
- R6: `reqAck` is high for exactly one cycle per accepted request. For a write it rises 5 clock edges after the accepting edge; for a read, 4 edges after it.
- R7: `memDataOe` is never high while `memOeN` is low, nor in the cycle after `memOeN` rises. The bus is therefore never driven by both sides.
- R8: `reqValid` pulses that arrive while an access is in progress are ignored. They produce no acknowledge and no write to the RAM.
- R9: Any address from 0 to 8191 can be written and read back, including both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Word address |
| reqWdata | input | 8 | Write byte |
| reqAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | 8 | Captured read byte, valid with `reqAck` after a read |
| memAddr | output | 13 | RAM address pins |
| memCe1N | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memDataOut | output | 8 | Byte to drive onto the RAM bus |
| memDataOe | output | 1 | Enable for the external bus driver |
| memDataIn | input | 8 | Byte read back from the RAM bus |

## Verification
Assertions check the pin-level rules on every cycle:
- the write strobe appears only while the chip is selected with outputs disabled, and lasts its exact width;
- the address holds steady while selected, and write data outlives the strobe;
- the controller never drives against an enabled or just-released RAM output;
- the acknowledge never repeats.

Some behaviour is visible only through the bench's behavioural RAM model:
- the bytes written actually land where expected;
- read data is captured only after the modelled access time;
- the accept-to-acknowledge latencies are as stated;
- requests raised while busy leave the memory and acknowledge untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_RACCESS = 3'd4,
    ST_RTURN   = 3'd5
  } seqState_t;

  // Pin-level strobes, one register per bit, handed from control to datapath.
  typedef struct packed {
    logic select;    // chip selected (both enables active)
    logic writeLow;  // write strobe asserted
    logic outLow;    // output enable asserted
    logic drive;     // controller drives the data bus
    logic capture;   // last access cycle of a read: sample the bus
  } strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WR_SETUP_CYC  = 1,
  parameter int WE_PULSE_CYC  = 2,
  parameter int WR_HOLD_CYC   = 1,
  parameter int RD_ACCESS_CYC = 3,
  parameter int RD_TURN_CYC   = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t strobeQ,
  output logic    latchReq,
  output logic    ackQ
);

  localparam int MAX_CYC = maxOf(maxOf(maxOf(WR_SETUP_CYC, WE_PULSE_CYC),
                                       maxOf(WR_HOLD_CYC, RD_ACCESS_CYC)),
                                 RD_TURN_CYC);
  localparam int CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  seqState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             lastCyc;
  logic             doneD;
  strobe_t          strobeD;

  assign lastCyc = (cntQ == '0);

  always_comb begin
    stateD   = stateQ;
    cntD     = lastCyc ? cntQ : cntQ - 1'b1;
    latchReq = 1'b0;
    doneD    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          latchReq = 1'b1;
          if (reqWrite) begin
            stateD = ST_WSETUP;
            cntD   = CNT_W'(WR_SETUP_CYC - 1);
          end else begin
            stateD = ST_RACCESS;
            cntD   = CNT_W'(RD_ACCESS_CYC - 1);
          end
        end
      end
      ST_WSETUP: if (lastCyc) begin
        stateD = ST_WPULSE;
        cntD   = CNT_W'(WE_PULSE_CYC - 1);
      end
      ST_WPULSE: if (lastCyc) begin
        stateD = ST_WHOLD;
        cntD   = CNT_W'(WR_HOLD_CYC - 1);
      end
      ST_WHOLD: if (lastCyc) begin
        stateD = ST_IDLE;
        doneD  = 1'b1;
      end
      ST_RACCESS: if (lastCyc) begin
        stateD = ST_RTURN;
        cntD   = CNT_W'(RD_TURN_CYC - 1);
        doneD  = 1'b1;
      end
      ST_RTURN: if (lastCyc) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  // Strobes follow the next state so every pin comes straight from a flop.
  always_comb begin
    strobeD.select   = (stateD == ST_WSETUP) || (stateD == ST_WPULSE) ||
                       (stateD == ST_WHOLD)  || (stateD == ST_RACCESS);
    strobeD.writeLow = (stateD == ST_WPULSE);
    strobeD.outLow   = (stateD == ST_RACCESS);
    strobeD.drive    = (stateD == ST_WPULSE) || (stateD == ST_WHOLD);
    strobeD.capture  = (stateD == ST_RACCESS) && (cntD == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      strobeQ <= '0;
      ackQ    <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      strobeQ <= strobeD;
      ackQ    <= doneD;
    end
  end

  // R6: the acknowledge is a single-cycle pulse
  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);

  // R8: no new request is taken while an access is under way
  p_busy_no_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |-> !latchReq);

  // R2: the idle state never leaves the chip selected
  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |-> !strobeQ.select && !strobeQ.drive);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int WE_PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobeQ,
  input  logic              latchReq,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobeQ.capture) rdataQ <= memDataIn;
    end
  end

  assign memAddr    = addrQ;
  assign memCe1N    = ~strobeQ.select;
  assign memCe2     = strobeQ.select;
  assign memWeN     = ~strobeQ.writeLow;
  assign memOeN     = ~strobeQ.outLow;
  assign memDataOut = wdataQ;
  assign memDataOe  = strobeQ.drive;
  assign rspRdata   = rdataQ;

  // Checker helper: length of the current write-strobe run.
  localparam int WCNT_W = $clog2(WE_PULSE_CYC + 2);
  logic [WCNT_W-1:0] weLowCnt;
  always_ff @(posedge clk) begin
    if (!rstN)        weLowCnt <= '0;
    else if (!memWeN) weLowCnt <= (weLowCnt == '1) ? weLowCnt : weLowCnt + 1'b1;
    else              weLowCnt <= '0;
  end

  logic chipSel;
  assign chipSel = !memCe1N && memCe2;

  p_we_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> chipSel && memOeN);

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == WCNT_W'(WE_PULSE_CYC)));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    chipSel && $past(chipSel) |-> $stable(memAddr));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDataOe && $stable(memDataOut));

  p_read_strobes_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> memWeN && chipSel);

  p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(!memOeN) |-> !memDataOe);

  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |-> memWeN && memOeN && !memDataOe);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W           = 13,
  parameter int DATA_W           = 8,
  parameter int CLK_NS           = 10,
  parameter int ACCESS_NS        = 20,
  parameter int SAMPLE_MARGIN_NS = 2,
  parameter int WE_PULSE_NS      = 15,
  parameter int DATA_SETUP_NS    = 10,
  parameter int OE_RELEASE_NS    = 8,
  parameter int WR_SETUP_CYC     = 1,
  parameter int WR_HOLD_CYC      = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn
);

  localparam int WE_PULSE_CYC  = maxOf(cdiv(WE_PULSE_NS, CLK_NS),
                                       cdiv(DATA_SETUP_NS, CLK_NS));
  localparam int RD_ACCESS_CYC = maxOf(1, cdiv(ACCESS_NS + SAMPLE_MARGIN_NS, CLK_NS));
  localparam int RD_TURN_CYC   = maxOf(1, cdiv(OE_RELEASE_NS, CLK_NS));

  strobe_t strobeQ;
  logic    latchReq;

  sram_ctrl_seq #(
    .WR_SETUP_CYC (WR_SETUP_CYC),
    .WE_PULSE_CYC (WE_PULSE_CYC),
    .WR_HOLD_CYC  (WR_HOLD_CYC),
    .RD_ACCESS_CYC(RD_ACCESS_CYC),
    .RD_TURN_CYC  (RD_TURN_CYC)
  ) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .strobeQ  (strobeQ),
    .latchReq (latchReq),
    .ackQ     (reqAck)
  );

  sram_ctrl_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WE_PULSE_CYC(WE_PULSE_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobeQ    (strobeQ),
    .latchReq   (latchReq),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .rspRdata   (rspRdata),
    .memAddr    (memAddr),
    .memCe1N    (memCe1N),
    .memCe2     (memCe2),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe),
    .memDataIn  (memDataIn)
  );

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int WR_LAT = 1 + 2 + 1 + 1; // setup + strobe + hold + ack register
  localparam int RD_LAT = 3 + 1;         // access + ack register

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqAck;
  logic [7:0]  rspRdata;
  logic [12:0] memAddr;
  logic        memCe1N, memCe2, memWeN, memOeN, memDataOe;
  logic [7:0]  memDataOut;
  logic [7:0]  memDataIn = 8'h3C;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int contention = 0;

  always #5 clk = ~clk;

  sram_async_ctrl u_sram_async_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rspRdata(rspRdata),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN),
    .memOeN(memOeN), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn)
  );

  // ---- behavioural RAM model ----
  logic [7:0] memArr [int];
  logic       readEn, relHold = 1'b0, winPrev = 1'b0, winNow, latchOk = 1'b0;
  logic [7:0] latchData = '0;
  int         rdAge = 0;

  assign readEn = !memCe1N && memCe2 && !memOeN && memWeN;

  function automatic logic [7:0] peek(input int a);
    return memArr.exists(a) ? memArr[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    relHold <= readEn;
    rdAge   <= readEn ? rdAge + 1 : 0;
  end

  always @(negedge clk) begin
    winNow = !memCe1N && memCe2 && !memWeN;
    if (winNow) begin
      latchData = memDataOut;
      latchOk   = memDataOe;
    end
    if (winPrev && !winNow) begin
      checks++;
      if (!latchOk || !memDataOe) begin
        fails++;
        $display("FAIL R4 data not held over strobe end: oe=%0b/%0b expected 1/1", latchOk, memDataOe);
      end
      memArr[int'(memAddr)] = latchData;
    end
    winPrev = winNow;
    if (memDataOe && (readEn || relHold)) begin
      contention++;
      fails++;
      $display("FAIL R7 bus contention at cycle %0d: actual drive=1 expected 0", cyc);
    end
    memDataIn = (readEn && rdAge >= 2) ? peek(int'(memAddr)) : 8'h3C;
  end

  // ---- watchdog ----
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual cycles %0d expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkIdlePins(input string req);
    check({req, " ce1N"}, memCe1N, 1);
    check({req, " ce2"}, memCe2, 0);
    check({req, " weN"}, memWeN, 1);
    check({req, " oeN"}, memOeN, 1);
    check({req, " drive"}, memDataOe, 0);
  endtask

  // Issue a request; return cycles to ack. busyPoke injects a write while busy.
  task automatic access(input logic wr, input logic [12:0] a, input logic [7:0] d,
                        input logic busyPoke, output int lat, output logic [7:0] rd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    if (busyPoke) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a + 13'd1; reqWdata = 8'h99;
    end
    while (!reqAck && lat < 50) begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
    end
    rd = rspRdata;
    @(negedge clk);
    check("R6 ack one cycle", reqAck, 0);
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d);
    int lat; logic [7:0] rd;
    access(1'b1, a, d, 1'b0, lat, rd);
    check("R6 write latency", lat, WR_LAT);
    check("R4 RAM content", peek(int'(a)), d);
  endtask

  task automatic doRead(input logic [12:0] a, input logic [7:0] exp, input string req);
    int lat; logic [7:0] rd;
    access(1'b0, a, 8'h00, 1'b0, lat, rd);
    check("R6 read latency", lat, RD_LAT);
    check(req, rd, exp);
  endtask

  task automatic testReset;
    @(negedge clk);
    checkIdlePins("R1 in reset");
    check("R1 ack in reset", reqAck, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdlePins("R1 after reset");
  endtask

  task automatic testPatterns;
    doWrite(13'h0005, 8'hA5);
    doWrite(13'h0A3C, 8'h5A);
    doWrite(13'h1234, 8'hFF);
    doRead(13'h0005, 8'hA5, "R5 read A5");
    doRead(13'h0A3C, 8'h5A, "R5 read 5A");
    doRead(13'h1234, 8'hFF, "R5 read FF");
    @(negedge clk);
    checkIdlePins("R2 between accesses");
  endtask

  task automatic testBoundary;
    doWrite(13'h0000, 8'h01);
    doWrite(13'h1FFF, 8'hFE);
    doRead(13'h0000, 8'h01, "R9 low address");
    doRead(13'h1FFF, 8'hFE, "R9 high address");
  endtask

  task automatic testTurnaround;
    // read immediately followed by write, then read: contention monitor watches
    doRead(13'h0005, 8'hA5, "R5 read before write");
    doWrite(13'h0006, 8'h77);
    doRead(13'h0006, 8'h77, "R7 read after turnaround");
    check("R7 no contention", contention, 0);
  endtask

  task automatic testBusyIgnored;
    int lat; int extra; logic [7:0] rd;
    doWrite(13'h0101, 8'h22);
    access(1'b1, 13'h0100, 8'h11, 1'b1, lat, rd);
    check("R8 latency with poke", lat, WR_LAT);
    extra = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (reqAck) extra++;
    end
    check("R8 no extra ack", extra, 0);
    doRead(13'h0101, 8'h22, "R8 busy write ignored");
    doRead(13'h0100, 8'h11, "R8 accepted write");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testPatterns();
    testBoundary();
    testTurnaround();
    testBusyIgnored();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule